// File: doc/BRIEF.md
# FPGA Configuration Handshake Sequencer

This block is the device-side sequencer of a configuration handshake carried on three open-drain style pins: a program-request pin, an init/error pin and a done pin. Each pin is modelled as a sampled input plus an output-enable/data pair. An open-drain low is `oe=1, out=0`. A released pin is `oe=0`, and a pull-up outside the block makes it read high. A falling edge on the program-request pin starts a configuration. The block holds the init pin low while it clears its configuration memory, then releases it. It waits for the pin to read high, so an outside agent can delay configuration by holding init low. It then takes a byte stream of `DATA_LEN` data bytes followed by a two-byte CRC. On a CRC match it wakes up; on a mismatch it reports the error on the init pin and stays down.

The done pin is held low during configuration. It is released only when the done bit is set and both the init and program-request pins read high. An optional wake-up rule also requires the done pin itself to read high before the user function is enabled. A JTAG-active input masks program requests. A mode strap hands all three pins to user logic. The sequence then starts by itself after reset and ignores the pins.

The states are IDLE, INIT, WAIT_INIT_HIGH, LOAD, CHECK, WAKEUP, USER and ERROR. The transitions are:
- IDLE→INIT when the strap is set.
- INIT→WAIT_INIT_HIGH after `INIT_CYCLES` cycles.
- WAIT_INIT_HIGH→LOAD when init reads high, or when the strap is set.
- LOAD→CHECK on the last CRC byte.
- CHECK→WAKEUP on a match, and CHECK→ERROR on a mismatch.
- WAKEUP→USER when the wake-up condition holds.
- Any state→INIT on a qualified program-request falling edge.

Top module: `cfg_handshake_seq`

## Requirements
- R1: After reset the state is IDLE. In IDLE the init pin is released (`init_oe=0`), the done pin is driven low (`done_oe=1, done_out=0`), `prog_oe=0` and `user_en=0`.
- R2: A falling edge on the program-request pin, seen after a two-flop synchronizer, moves the block to INIT from any state, including USER and ERROR. INIT drives the init pin low for exactly `INIT_CYCLES` cycles and then releases it.
- R3: While `jtag_active=1`, falling edges on the program-request pin have no effect: a configured block keeps `user_en=1` and its done pin released.
- R4: After INIT the block accepts no stream byte until the synchronized init pin reads high. Bytes presented while init is held low outside the block are discarded.
- R5: In LOAD each cycle with `cfg_valid=1` takes one byte: first `DATA_LEN` data bytes, then the received CRC, high byte first. The computed CRC is CRC-16 with polynomial 0x8005, initial value 0, MSB-first, no reflection and no final XOR, taken over the data bytes only.
- R6: A CRC mismatch enters ERROR. There the init pin is driven low, the done pin is driven low and `user_en=0`, and the block stays there until a new qualified program-request falling edge.
- R7: The done pin is driven low in every state except WAKEUP and USER. In those two states it is released only while the synchronized init and program-request pins both read high. With `DONE_PUSH_PULL=1` it is then driven high (`done_oe=1, done_out=1`) instead of being released.
- R8: With `wake_wait_done=1`, `user_en` stays 0 while the done pin is held low outside the block, and it rises after the pin reads high. With `wake_wait_done=0`, wake-up does not look at the done pin.
- R9: With `strap_user=1`, each pin's `*_oe`/`*_out` equal the matching `usr_*` inputs. The sequence leaves IDLE on its own, does not wait on the init or done pins, and ignores program-request edges.
- R10: `user_en` is 1 only in USER and falls as soon as a new configuration starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_user | input | 1 | Mode strap: 1 hands the three pins to user logic |
| jtag_active | input | 1 | JTAG mode active; masks program requests |
| wake_wait_done | input | 1 | Wake-up option: wait for the done pin to read high |
| prog_in | input | 1 | Sampled program-request pin |
| prog_oe | output | 1 | Program-request pin output enable |
| prog_out | output | 1 | Program-request pin output data |
| init_in | input | 1 | Sampled init/error pin |
| init_oe | output | 1 | Init pin output enable |
| init_out | output | 1 | Init pin output data |
| done_in | input | 1 | Sampled done pin |
| done_oe | output | 1 | Done pin output enable |
| done_out | output | 1 | Done pin output data |
| usr_prog_oe | input | 1 | User-mode output enable for the program-request pin |
| usr_prog_out | input | 1 | User-mode data for the program-request pin |
| usr_init_oe | input | 1 | User-mode output enable for the init pin |
| usr_init_out | input | 1 | User-mode data for the init pin |
| usr_done_oe | input | 1 | User-mode output enable for the done pin |
| usr_done_out | input | 1 | User-mode data for the done pin |
| cfg_valid | input | 1 | Stream byte valid |
| cfg_byte | input | 8 | Stream byte |
| user_en | output | 1 | User-function enable |

## Verification
The bench loads good streams with several data patterns and measures the init-low window from a falling program request. It then flips each of the sixteen CRC bits in turn. A block that compared the wrong byte order or polynomial would reject good streams; one that let ERROR time out would wake up and raise `user_en`. The bench also sends a corrupt stream while init is held low outside the block. A sequencer that counted those bytes would land in ERROR and refuse the later good stream. Further runs cover program pulses under JTAG, a held-low done pin with the wait option, the push-pull done variant, and the strap mode. In strap mode the bench sweeps all 64 user pin combinations and checks that a low init level does not stall the sequence.

// File: rtl/cfg_hs_pkg.sv
package cfg_hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_WAIT_INIT_HIGH,
        ST_LOAD,
        ST_CHECK,
        ST_WAKEUP,
        ST_USER,
        ST_ERROR
    } cfg_state_e;

    localparam logic [15:0] CRC16_POLY = 16'h8005;

    // One byte through the CRC register, most significant bit first
    function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic [7:0] data);
        logic [15:0] c;
        logic        fb;
        c = cur;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ data[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC16_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/cfg_hs_sync.sv
module cfg_hs_sync #(
    parameter int          WIDTH   = 1,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                stab_q <= RST_VAL;
            end else begin
                meta_q <= d[g];
                stab_q <= meta_q;
            end
        end
        assign q[g] = stab_q;
    end
endmodule

// File: rtl/cfg_hs_crc16.sv
module cfg_hs_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    import cfg_hs_pkg::*;

    logic [15:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc_q <= '0;
        else if (clear) crc_q <= '0;
        else if (en)    crc_q <= crc16_step(crc_q, data);
    end

    assign crc = crc_q;
endmodule

// File: rtl/cfg_hs_pad.sv
module cfg_hs_pad #(
    parameter bit PUSH_PULL = 1'b0
) (
    input  logic strap_user,
    input  logic cfg_low,
    input  logic usr_oe,
    input  logic usr_out,
    output logic pad_oe,
    output logic pad_out
);
    logic cfg_oe, cfg_out;

    if (PUSH_PULL) begin : g_pp
        assign cfg_oe  = 1'b1;
        assign cfg_out = ~cfg_low;
    end else begin : g_od
        assign cfg_oe  = cfg_low;
        assign cfg_out = 1'b0;
    end

    assign pad_oe  = strap_user ? usr_oe  : cfg_oe;
    assign pad_out = strap_user ? usr_out : cfg_out;
endmodule

// File: rtl/cfg_handshake_seq.sv
module cfg_handshake_seq #(
    parameter int INIT_CYCLES    = 16,
    parameter int DATA_LEN       = 8,
    parameter bit DONE_PUSH_PULL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_user,
    input  logic       jtag_active,
    input  logic       wake_wait_done,
    input  logic       prog_in,
    output logic       prog_oe,
    output logic       prog_out,
    input  logic       init_in,
    output logic       init_oe,
    output logic       init_out,
    input  logic       done_in,
    output logic       done_oe,
    output logic       done_out,
    input  logic       usr_prog_oe,
    input  logic       usr_prog_out,
    input  logic       usr_init_oe,
    input  logic       usr_init_out,
    input  logic       usr_done_oe,
    input  logic       usr_done_out,
    input  logic       cfg_valid,
    input  logic [7:0] cfg_byte,
    output logic       user_en
);
    import cfg_hs_pkg::*;

    localparam int TOTAL_BYTES = DATA_LEN + 2;
    localparam int CNT_W       = $clog2(TOTAL_BYTES + 1);
    localparam int IC_W        = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL_BYTES - 1);
    localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_LEN);
    localparam logic [IC_W-1:0]  INIT_END = IC_W'(INIT_CYCLES - 1);

    // ---------------- pin synchronizers and edge detect ----------------
    logic [2:0] pins_s;
    logic       prog_s, init_s, done_s;
    logic       prog_prev_q;
    logic       prog_fall;

    cfg_hs_sync #(.WIDTH(3), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({done_in, init_in, prog_in}),
        .q     (pins_s)
    );
    assign {done_s, init_s, prog_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prog_prev_q <= 1'b1;
        else        prog_prev_q <= prog_s;
    end

    assign prog_fall = prog_prev_q & ~prog_s & ~jtag_active & ~strap_user;

    // ---------------- state and datapath registers ----------------
    cfg_state_e       state_q, state_d;
    logic [IC_W-1:0]  init_cnt_q;
    logic [CNT_W-1:0] byte_cnt_q;
    logic [15:0]      rx_crc_q;
    logic [15:0]      calc_crc;
    logic             done_bit_q;
    logic             take;
    logic             last_byte;
    logic             crc_ok;
    logic             done_release;
    logic             wake_ok;

    assign take      = (state_q == ST_LOAD) && cfg_valid;
    assign last_byte = (byte_cnt_q == LAST_IDX);
    assign crc_ok    = (calc_crc == rx_crc_q);

    cfg_hs_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_INIT),
        .en    (take && (byte_cnt_q < DATA_END)),
        .data  (cfg_byte),
        .crc   (calc_crc)
    );

    assign done_release = done_bit_q && (strap_user || (init_s && prog_s));
    assign wake_ok      = strap_user || (done_release && (!wake_wait_done || done_s));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:           if (strap_user) state_d = ST_INIT;
            ST_INIT:           if (init_cnt_q == INIT_END) state_d = ST_WAIT_INIT_HIGH;
            ST_WAIT_INIT_HIGH: if (strap_user || init_s) state_d = ST_LOAD;
            ST_LOAD:           if (take && last_byte) state_d = ST_CHECK;
            ST_CHECK:          state_d = crc_ok ? ST_WAKEUP : ST_ERROR;
            ST_WAKEUP:         if (wake_ok) state_d = ST_USER;
            ST_USER:           state_d = ST_USER;
            ST_ERROR:          state_d = ST_ERROR;
            default:           state_d = ST_IDLE;
        endcase
        if (prog_fall) state_d = ST_INIT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt_q <= '0;
            byte_cnt_q <= '0;
            rx_crc_q   <= '0;
            done_bit_q <= 1'b0;
        end else begin
            init_cnt_q <= (state_q == ST_INIT && !prog_fall) ? init_cnt_q + 1'b1 : '0;
            if (state_q == ST_INIT) begin
                byte_cnt_q <= '0;
                rx_crc_q   <= '0;
            end else if (take) begin
                byte_cnt_q <= byte_cnt_q + 1'b1;
                if (byte_cnt_q >= DATA_END) rx_crc_q <= {rx_crc_q[7:0], cfg_byte};
            end
            if (prog_fall || state_q == ST_INIT) done_bit_q <= 1'b0;
            else if (state_q == ST_CHECK && crc_ok) done_bit_q <= 1'b1;
        end
    end

    // ---------------- outputs ----------------
    logic init_low, done_low;

    always_comb begin
        init_low = 1'b0;
        user_en  = 1'b0;
        unique case (state_q)
            ST_INIT, ST_ERROR: init_low = 1'b1;
            ST_USER:           user_en  = 1'b1;
            default:           ;
        endcase
        done_low = !done_release;
    end

    cfg_hs_pad #(.PUSH_PULL(1'b0)) u_pad_prog (
        .strap_user (strap_user), .cfg_low (1'b0),
        .usr_oe (usr_prog_oe), .usr_out (usr_prog_out),
        .pad_oe (prog_oe), .pad_out (prog_out)
    );

    cfg_hs_pad #(.PUSH_PULL(1'b0)) u_pad_init (
        .strap_user (strap_user), .cfg_low (init_low),
        .usr_oe (usr_init_oe), .usr_out (usr_init_out),
        .pad_oe (init_oe), .pad_out (init_out)
    );

    cfg_hs_pad #(.PUSH_PULL(DONE_PUSH_PULL)) u_pad_done (
        .strap_user (strap_user), .cfg_low (done_low),
        .usr_oe (usr_done_oe), .usr_out (usr_done_out),
        .pad_oe (done_oe), .pad_out (done_out)
    );

    // ---------------- assertions ----------------
    AST_INIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && init_cnt_q != INIT_END && !prog_fall) |=> state_q == ST_INIT); // R2

    AST_JTAG_HOLDS_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_active && state_q == ST_USER) |=> state_q == ST_USER); // R3

    AST_NO_LOAD_WHILE_INIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_INIT_HIGH && !init_s && !strap_user) |=> state_q != ST_LOAD); // R4

    AST_CHECK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK) |=> state_q inside {ST_WAKEUP, ST_ERROR, ST_INIT}); // R5

    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERROR && !prog_fall) |=> state_q == ST_ERROR); // R6

    AST_DONE_LOW_IN_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_user && !(state_q inside {ST_WAKEUP, ST_USER})) |-> (done_oe && !done_out)); // R7

    AST_USER_FROM_WAKEUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_en) |-> $past(state_q) == ST_WAKEUP); // R8

endmodule

// File: tb/cfg_handshake_seq_tb_top.sv
module cfg_handshake_seq_tb_top;

    localparam int INIT_N = 6;
    localparam int DLEN   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       strap_user = 0, jtag_active = 0, wake_wait_done = 0;
    logic       prog_drv = 1, ext_init_low = 0, ext_done_low = 0;
    logic       usr_prog_oe = 0, usr_prog_out = 0, usr_init_oe = 0, usr_init_out = 0;
    logic       usr_done_oe = 0, usr_done_out = 0;
    logic       cfg_valid = 0;
    logic [7:0] cfg_byte = 0;

    logic prog_oe, prog_out, init_oe, init_out, done_oe, done_out, user_en;
    logic init_pin, done_pin;
    logic pp_prog_oe, pp_prog_out, pp_init_oe, pp_init_out, pp_done_oe, pp_done_out, pp_user_en;
    logic pp_init_pin, pp_done_pin;

    // open-drain pin models with pull-up
    assign init_pin    = !((init_oe && !init_out) || ext_init_low);
    assign done_pin    = !((done_oe && !done_out) || ext_done_low);
    assign pp_init_pin = !((pp_init_oe && !pp_init_out) || ext_init_low);
    assign pp_done_pin = !((pp_done_oe && !pp_done_out) || ext_done_low);

    cfg_handshake_seq #(.INIT_CYCLES(INIT_N), .DATA_LEN(DLEN), .DONE_PUSH_PULL(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_user(strap_user), .jtag_active(jtag_active),
        .wake_wait_done(wake_wait_done),
        .prog_in(prog_drv), .prog_oe(prog_oe), .prog_out(prog_out),
        .init_in(init_pin), .init_oe(init_oe), .init_out(init_out),
        .done_in(done_pin), .done_oe(done_oe), .done_out(done_out),
        .usr_prog_oe(usr_prog_oe), .usr_prog_out(usr_prog_out),
        .usr_init_oe(usr_init_oe), .usr_init_out(usr_init_out),
        .usr_done_oe(usr_done_oe), .usr_done_out(usr_done_out),
        .cfg_valid(cfg_valid), .cfg_byte(cfg_byte), .user_en(user_en)
    );

    cfg_handshake_seq #(.INIT_CYCLES(INIT_N), .DATA_LEN(DLEN), .DONE_PUSH_PULL(1'b1)) dut_pp_i (
        .clk(clk), .rst_n(rst_n), .strap_user(strap_user), .jtag_active(jtag_active),
        .wake_wait_done(wake_wait_done),
        .prog_in(prog_drv), .prog_oe(pp_prog_oe), .prog_out(pp_prog_out),
        .init_in(pp_init_pin), .init_oe(pp_init_oe), .init_out(pp_init_out),
        .done_in(pp_done_pin), .done_oe(pp_done_oe), .done_out(pp_done_out),
        .usr_prog_oe(usr_prog_oe), .usr_prog_out(usr_prog_out),
        .usr_init_oe(usr_init_oe), .usr_init_out(usr_init_out),
        .usr_done_oe(usr_done_oe), .usr_done_out(usr_done_out),
        .cfg_valid(cfg_valid), .cfg_byte(cfg_byte), .user_en(pp_user_en)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int seed, input int idx);
        return 8'((seed * 53 + idx * 29 + 17) & 255);
    endfunction

    // CRC-16, poly 0x8005, init 0, MSB first, computed bit by bit on ints
    function automatic int ref_crc(input int seed);
        int c = 0;
        for (int i = 0; i < DLEN; i++) begin
            int b = int'(pat(seed, i));
            for (int k = 7; k >= 0; k--) begin
                int top = (c >> 15) & 1;
                int bit_in = (b >> k) & 1;
                c = (c << 1) & 16'hFFFF;
                if ((top ^ bit_in) != 0) c = c ^ 16'h8005;
            end
        end
        return c;
    endfunction

    // start a configuration and return how long init stays driven low
    task automatic start_cfg(output int low_len);
        prog_drv = 0;
        low_len = 0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (init_oe && !init_out) break;
        end
        while (init_oe && !init_out && low_len < 100) begin
            low_len++;
            @(negedge clk);
        end
        prog_drv = 1;
    endtask

    task automatic send_stream(input int seed, input int crc_flip);
        int c = ref_crc(seed) ^ crc_flip;
        for (int i = 0; i < DLEN; i++) begin
            cfg_valid = 1; cfg_byte = pat(seed, i);
            @(negedge clk);
        end
        cfg_valid = 1; cfg_byte = 8'(c >> 8);  @(negedge clk);
        cfg_valid = 1; cfg_byte = 8'(c);       @(negedge clk);
        cfg_valid = 0; cfg_byte = 0;
    endtask

    task automatic wait_user(input int limit, output int got);
        got = 0;
        for (int t = 0; t < limit; t++) begin
            if (user_en) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int len, got;
        cyc(3);
        rst_n = 1;
        cyc(2);

        // R1: reset state
        chk("R1 init_oe", int'(init_oe), 0);
        chk("R1 done low", int'({done_oe, done_out}), 2);
        chk("R1 prog_oe", int'(prog_oe), 0);
        chk("R1 user_en", int'(user_en), 0);
        cyc(10);
        chk("R1 idle stays", int'(user_en), 0);

        // R2/R5/R7/R8/R10: good streams over several patterns
        for (int s = 0; s < 4; s++) begin
            start_cfg(len);
            chk("R2 init window", len, INIT_N);
            chk("R10 user_en low in config", int'(user_en), 0);
            chk("R7 done low in config", int'({done_oe, done_out}), 2);
            cyc(6);
            send_stream(s, 0);
            wait_user(20, got);
            chk("R5 good crc wakes", got, 1);
            chk("R7 done released", int'(done_oe), 0);
            chk("R7 push-pull done high", int'({pp_done_oe, pp_done_out}), 3);
            chk("R8 push-pull user_en", int'(pp_user_en), 1);
        end

        // R6: every single-bit CRC corruption, recovery by a new request
        for (int b = 0; b < 16; b++) begin
            start_cfg(len);
            chk("R2 restart from user/error", int'(len >= INIT_N), 1);
            cyc(6);
            send_stream(b + 7, 1 << b);
            cyc(4);
            chk("R6 init low on error", int'(init_pin), 0);
            chk("R6 done low on error", int'(done_pin), 0);
            cyc(15);
            chk("R6 stays down", int'(user_en), 0);
        end
        start_cfg(len);
        cyc(6);
        send_stream(3, 0);
        wait_user(20, got);
        chk("R2 recover from error", got, 1);

        // R3: jtag masks program requests
        jtag_active = 1;
        cyc(2);
        prog_drv = 0; cyc(6); prog_drv = 1; cyc(10);
        chk("R3 user_en kept", int'(user_en), 1);
        chk("R3 done kept released", int'(done_pin), 1);
        jtag_active = 0;
        cyc(5);

        // R4: stream during external init hold is discarded
        ext_init_low = 1;
        start_cfg(len);
        cyc(6);
        send_stream(9, 16'h0101);
        cyc(6);
        chk("R4 held, no wake", int'(user_en), 0);
        ext_init_low = 0;
        cyc(8);
        chk("R4 init released not error", int'(init_pin), 1);
        send_stream(10, 0);
        wait_user(20, got);
        chk("R4 good stream after hold", got, 1);

        // R8: wait for externally held done
        wake_wait_done = 1;
        ext_done_low = 1;
        start_cfg(len);
        cyc(6);
        send_stream(11, 0);
        cyc(20);
        chk("R8 held done blocks wake", int'(user_en), 0);
        ext_done_low = 0;
        wait_user(20, got);
        chk("R8 wake after done high", got, 1);
        wake_wait_done = 0;

        // R9: strap mode
        strap_user = 1;
        rst_n = 0; cyc(2); rst_n = 1;
        for (int v = 0; v < 64; v++) begin
            {usr_prog_oe, usr_prog_out, usr_init_oe, usr_init_out, usr_done_oe, usr_done_out} = 6'(v);
            #1;
            chk("R9 pins follow user", int'({prog_oe, prog_out, init_oe, init_out, done_oe, done_out}), v);
            @(negedge clk);
        end
        usr_init_oe = 1; usr_init_out = 0; usr_done_oe = 1; usr_done_out = 0;
        usr_prog_oe = 0; usr_prog_out = 0;
        cyc(5);
        chk("R9 init pin low by user", int'(init_pin), 0);
        send_stream(12, 0);
        wait_user(20, got);
        chk("R9 self-start ignores pins", got, 1);
        prog_drv = 0; cyc(6); prog_drv = 1; cyc(10);
        chk("R9 prog edge ignored", int'(user_en), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule